// File: doc/BRIEF.md
# Flash Security Unlock Controller

This block keeps the flash option settings of a small controller and decides whether the part is secured. During reset it copies a nonvolatile option byte into a holding register. The byte carries a key-enable bit, a vector-redirection-disable bit and a two-bit security code. After reset these fields do not change. The only exception is the security code, which can switch to the open value.

There are two ways to release security. The first is that firmware writes eight key bytes that match a stored 64-bit backdoor key, in byte order. The second is that a blank-check-passed pulse arrives. Either way, the part stays open until the next reset. Key writes that come from the debug path have no effect. A wrong firmware byte locks the key path out until reset. The `secure_o` flag tells the debug access path to block memory reads and writes.

The control state machine has four states:

- `ST_ARMED`: secured, with no key bytes matched yet.
- `ST_COLLECT`: secured, with a partial match in progress.
- `ST_BARRED`: secured, with the key path closed because the key-enable bit is 0 or a byte did not match.
- `ST_OPEN`: unsecured.

Its transitions are:

- **arm_to_collect**: a matching firmware byte arrives while no bytes are matched.
- **collect_advance**: a matching byte arrives that is not the last one.
- **collect_to_open**: the last byte matches.
- **any_mismatch_to_barred**: a wrong firmware byte arrives in `ST_ARMED` or `ST_COLLECT`.
- **blank_to_open**: a blank pulse arrives in any secured state.
- **reset_entry**: on reset the machine goes to `ST_OPEN` if the code is 10, to `ST_ARMED` if the key-enable bit is 1, and to `ST_BARRED` otherwise.

Top module: `fsec_unlock`

## Requirements
- R1: While `rst_n` is low, the block captures `nv_opt_i`. `key_en_o` follows bit 7 and `sec_code_o` follows bits 1:0. Changes to `nv_opt_i` after reset have no effect on any output.
- R2: `redir_dis_o` follows the captured bit 6. A value of 1 means vector redirection is disabled and 0 means it is enabled.
- R3: The security code 2'b10 means unsecured. The codes 00, 01 and 11 mean secured. `secure_o` is 1 exactly when `sec_code_o` is not 2'b10.
- R4: When the captured key-enable bit is 0, no firmware key write can clear `secure_o`.
- R5: A firmware write has `key_wr_i`=1 and `key_dbg_i`=0. Eight firmware writes must match `nv_key_i` byte 0 (bits 7:0) up to byte 7 (bits 63:56), in that order. When they do, `secure_o` is 0 and `sec_code_o` is 2'b10 from the clock edge that samples the eighth write. After seven matching bytes the part is still secured.
- R6: A write with `key_dbg_i`=1 is ignored. It neither advances nor aborts a key sequence.
- R7: A firmware byte that does not match clears the progress. All later key writes are then ignored until reset.
- R8: A `blank_ok_i` pulse in any secured state makes `secure_o` 0 and `sec_code_o` 2'b10 from the edge that samples it. This holds whatever the key-enable bit or lockout state.
- R9: Once unsecured, the block stays unsecured until reset, and further key writes are ignored. A reset reloads the option byte and relocks the part if the byte's code is a secured code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; option byte captured while low |
| nv_opt_i | input | 8 | Nonvolatile option byte image |
| nv_key_i | input | 64 | Nonvolatile backdoor key, byte 0 in bits 7:0 |
| key_wr_i | input | 1 | Key byte write strobe |
| key_dbg_i | input | 1 | Marks the write as coming from the debug path |
| key_byte_i | input | 8 | Key byte being written |
| blank_ok_i | input | 1 | Blank check passed pulse |
| secure_o | output | 1 | Part secured; debug memory access blocked |
| sec_code_o | output | 2 | Live security code |
| key_en_o | output | 1 | Captured key-enable bit |
| redir_dis_o | output | 1 | Captured vector-redirection-disable bit |

## Verification
The hardest situation to reach is a partial match that is still in progress when debug-tagged writes arrive. Those writes must leave the byte index unchanged, even when they carry the byte expected next or a wrong one. The stimulus therefore interleaves debug writes of both kinds between the firmware bytes. It also runs a full debug-only sequence and follows it with a good firmware sequence, which shows that no progress and no lockout was left behind. A lockout after a mismatch mid-sequence is then cleared only by a blank pulse, and a behavioural model checks every output on every clock.

// File: rtl/fsec_pkg.sv
package fsec_pkg;

    localparam int unsigned OPT_W     = 8;
    localparam int unsigned KEYEN_BIT = 7;
    localparam int unsigned NORED_BIT = 6;
    localparam int unsigned SEC_LSB   = 0;
    localparam int unsigned SEC_W     = 2;

    localparam logic [SEC_W-1:0] SEC_OPEN = 2'b10;

    typedef struct packed {
        logic             key_en;
        logic             redir_dis;
        logic [SEC_W-1:0] sec;
    } opt_t;

    typedef enum logic [1:0] {
        ST_ARMED   = 2'd0,
        ST_COLLECT = 2'd1,
        ST_BARRED  = 2'd2,
        ST_OPEN    = 2'd3
    } sec_state_e;

endpackage

// File: rtl/fsec_optreg.sv
module fsec_optreg
    import fsec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPT_W-1:0] nv_opt,
    output opt_t             nv_fields,
    output opt_t             opt_q
);

    logic unused_rsv_bits;

    always_comb begin
        nv_fields.key_en    = nv_opt[KEYEN_BIT];
        nv_fields.redir_dis = nv_opt[NORED_BIT];
        nv_fields.sec       = nv_opt[SEC_LSB +: SEC_W];
    end

    assign unused_rsv_bits = ^nv_opt[NORED_BIT-1:SEC_LSB+SEC_W];

    // Capture only while reset is held; frozen afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opt_q <= nv_fields;
        end
    end

endmodule

// File: rtl/fsec_keysel.sv
module fsec_keysel #(
    parameter int unsigned KEY_BYTES = 8,
    parameter int unsigned BYTE_W    = 8,
    localparam int unsigned KEY_W    = KEY_BYTES * BYTE_W,
    localparam int unsigned IDX_W    = (KEY_BYTES > 1) ? $clog2(KEY_BYTES) : 1
) (
    input  logic [KEY_W-1:0]  key_flat,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] wr_byte,
    output logic              hit
);

    logic [BYTE_W-1:0] key_arr [KEY_BYTES];

    for (genvar g = 0; g < KEY_BYTES; g++) begin : g_slice
        assign key_arr[g] = key_flat[g*BYTE_W +: BYTE_W];
    end

    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < KEY_BYTES; i++) begin
            if (idx == IDX_W'(i)) begin
                hit = (key_arr[i] == wr_byte);
            end
        end
    end

endmodule

// File: rtl/fsec_fsm.sv
module fsec_fsm
    import fsec_pkg::*;
#(
    parameter int unsigned KEY_BYTES = 8,
    localparam int unsigned IDX_W    = (KEY_BYTES > 1) ? $clog2(KEY_BYTES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rst_key_en,
    input  logic [SEC_W-1:0] rst_sec,
    input  logic [SEC_W-1:0] held_sec,
    input  logic             fw_wr,
    input  logic             hit,
    input  logic             blank_ok,
    output logic [IDX_W-1:0] idx,
    output logic             secure,
    output logic [SEC_W-1:0] sec_code
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(KEY_BYTES - 1);

    sec_state_e       state_q, state_d, entry_state;
    logic [IDX_W-1:0] idx_q, idx_d;

    always_comb begin
        if (rst_sec == SEC_OPEN) begin
            entry_state = ST_OPEN;
        end else if (rst_key_en) begin
            entry_state = ST_ARMED;
        end else begin
            entry_state = ST_BARRED;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= entry_state;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_ARMED, ST_COLLECT: begin
                if (blank_ok) begin
                    state_d = ST_OPEN;
                    idx_d   = '0;
                end else if (fw_wr) begin
                    if (!hit) begin
                        state_d = ST_BARRED;
                        idx_d   = '0;
                    end else if (idx_q == LAST_IDX) begin
                        state_d = ST_OPEN;
                        idx_d   = '0;
                    end else begin
                        state_d = ST_COLLECT;
                        idx_d   = idx_q + 1'b1;
                    end
                end
            end
            ST_BARRED: begin
                if (blank_ok) begin
                    state_d = ST_OPEN;
                end
            end
            ST_OPEN: begin
                state_d = ST_OPEN;
            end
        endcase
    end

    always_comb begin
        idx = idx_q;
        unique case (state_q)
            ST_OPEN: begin
                secure   = 1'b0;
                sec_code = SEC_OPEN;
            end
            ST_ARMED, ST_COLLECT, ST_BARRED: begin
                secure   = 1'b1;
                sec_code = held_sec;
            end
        endcase
    end

endmodule

// File: rtl/fsec_unlock.sv
module fsec_unlock
    import fsec_pkg::*;
#(
    parameter int unsigned KEY_BYTES = 8,
    parameter int unsigned BYTE_W    = 8,
    localparam int unsigned KEY_W    = KEY_BYTES * BYTE_W,
    localparam int unsigned IDX_W    = (KEY_BYTES > 1) ? $clog2(KEY_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OPT_W-1:0]  nv_opt_i,
    input  logic [KEY_W-1:0]  nv_key_i,
    input  logic              key_wr_i,
    input  logic              key_dbg_i,
    input  logic [BYTE_W-1:0] key_byte_i,
    input  logic              blank_ok_i,
    output logic              secure_o,
    output logic [SEC_W-1:0]  sec_code_o,
    output logic              key_en_o,
    output logic              redir_dis_o
);

    opt_t             nv_fields;
    opt_t             opt_q;
    logic [IDX_W-1:0] idx;
    logic             hit;
    logic             fw_wr;
    logic             unused_nv_redir;

    assign fw_wr           = key_wr_i & ~key_dbg_i;
    assign unused_nv_redir = nv_fields.redir_dis;

    fsec_optreg u_optreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .nv_opt    (nv_opt_i),
        .nv_fields (nv_fields),
        .opt_q     (opt_q)
    );

    fsec_keysel #(
        .KEY_BYTES (KEY_BYTES),
        .BYTE_W    (BYTE_W)
    ) u_keysel (
        .key_flat (nv_key_i),
        .idx      (idx),
        .wr_byte  (key_byte_i),
        .hit      (hit)
    );

    fsec_fsm #(
        .KEY_BYTES (KEY_BYTES)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_key_en (nv_fields.key_en),
        .rst_sec    (nv_fields.sec),
        .held_sec   (opt_q.sec),
        .fw_wr      (fw_wr),
        .hit        (hit),
        .blank_ok   (blank_ok_i),
        .idx        (idx),
        .secure     (secure_o),
        .sec_code   (sec_code_o)
    );

    assign key_en_o    = opt_q.key_en;
    assign redir_dis_o = opt_q.redir_dis;

endmodule

// File: rtl/fsec_unlock_chk.sv
module fsec_unlock_chk
    import fsec_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             key_wr_i,
    input logic             key_dbg_i,
    input logic             blank_ok_i,
    input logic             secure_o,
    input logic [SEC_W-1:0] sec_code_o,
    input logic             key_en_o,
    input logic             redir_dis_o
);

    AST_OPT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(key_en_o) && $stable(redir_dis_o))); // R1

    AST_CODE_MATCHES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        secure_o == (sec_code_o != SEC_OPEN)); // R3

    AST_KEYEN_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (secure_o && !key_en_o && !blank_ok_i) |=> secure_o); // R4

    AST_DBG_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (secure_o && key_wr_i && key_dbg_i && !blank_ok_i) |=> secure_o); // R6

    AST_UNLOCK_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(secure_o)) |->
            $past((key_wr_i && !key_dbg_i) || blank_ok_i)); // R5

    AST_OPEN_IS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !secure_o |=> !secure_o); // R9

endmodule

bind fsec_unlock fsec_unlock_chk u_chk (.*);

// File: tb/fsec_unlock_tb.sv
module fsec_unlock_tb;

    localparam int KB = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  nv_opt;
    logic [63:0] nv_key;
    logic        key_wr, key_dbg, blank_ok;
    logic [7:0]  key_byte;
    logic        secure, key_en, redir;
    logic [1:0]  code;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    fsec_unlock u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .nv_opt_i    (nv_opt),
        .nv_key_i    (nv_key),
        .key_wr_i    (key_wr),
        .key_dbg_i   (key_dbg),
        .key_byte_i  (key_byte),
        .blank_ok_i  (blank_ok),
        .secure_o    (secure),
        .sec_code_o  (code),
        .key_en_o    (key_en),
        .redir_dis_o (redir)
    );

    // Behavioural reference model
    bit         m_open, m_barred;
    int         m_got;
    logic [7:0] m_opt;
    logic [7:0] key_q[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_opt    = nv_opt;
            m_open   = (nv_opt[1:0] == 2'b10);
            m_barred = !nv_opt[7];
            m_got    = 0;
            key_q.delete();
            for (int i = 0; i < KB; i++) key_q.push_back(nv_key[i*8 +: 8]);
        end else if (!m_open) begin
            if (blank_ok) begin
                m_open = 1'b1;
                m_got  = 0;
            end else if (key_wr && !key_dbg && !m_barred) begin
                if (key_byte == key_q[m_got]) begin
                    m_got++;
                    if (m_got == KB) begin
                        m_open = 1'b1;
                        m_got  = 0;
                    end
                end else begin
                    m_barred = 1'b1;
                    m_got    = 0;
                end
            end
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            check("R3 model secure", {7'd0, secure}, {7'd0, !m_open});
            check("R5 model code", {6'd0, code}, m_open ? 8'h02 : {6'd0, m_opt[1:0]});
            check("R1 model key_en", {7'd0, key_en}, {7'd0, m_opt[7]});
            check("R2 model redir", {7'd0, redir}, {7'd0, m_opt[6]});
        end
    end

    task automatic do_reset(input logic [7:0] opt);
        @(posedge clk); #1;
        rst_n = 1'b0; nv_opt = opt;
        key_wr = 1'b0; key_dbg = 1'b0; blank_ok = 1'b0; key_byte = 8'h00;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] b, input logic dbg);
        key_wr = 1'b1; key_dbg = dbg; key_byte = b;
        @(posedge clk); #1;
        key_wr = 1'b0; key_dbg = 1'b0;
    endtask

    task automatic pulse_blank();
        blank_ok = 1'b1;
        @(posedge clk); #1;
        blank_ok = 1'b0;
    endtask

    function automatic logic [7:0] kb(input int i);
        return nv_key[i*8 +: 8];
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; nv_opt = 8'h80; nv_key = 64'h0123_4567_89AB_CDEF;
        key_wr = 1'b0; key_dbg = 1'b0; blank_ok = 1'b0; key_byte = 8'h00;

        // Reset state and frozen options
        do_reset(8'h80);
        check("R1 key_en at reset", {7'd0, key_en}, 8'h01);
        check("R3 secure at reset", {7'd0, secure}, 8'h01);
        check("R1 code at reset", {6'd0, code}, 8'h00);
        nv_opt = 8'h42;
        repeat (3) @(posedge clk); #1;
        check("R1 nv change ignored key_en", {7'd0, key_en}, 8'h01);
        check("R1 nv change ignored secure", {7'd0, secure}, 8'h01);

        // Correct sequence, debug writes interleaved
        do_reset(8'h83);
        for (int i = 0; i < KB; i++) begin
            wr(kb(i), 1'b1);
            wr(8'h5A, 1'b1);
            if (i == KB - 1) check("R5 secured after seven bytes", {7'd0, secure}, 8'h01);
            wr(kb(i), 1'b0);
        end
        check("R5 open after eighth byte", {7'd0, secure}, 8'h00);
        check("R5 code open", {6'd0, code}, 8'h02);
        check("R6 debug writes did not abort", {7'd0, secure}, 8'h00);
        wr(8'h00, 1'b0);
        repeat (2) @(posedge clk); #1;
        check("R9 stays open", {7'd0, secure}, 8'h00);
        do_reset(8'h83);
        check("R9 relocked by reset", {7'd0, secure}, 8'h01);
        check("R9 code reloaded", {6'd0, code}, 8'h03);

        // Debug-only sequence, then a clean firmware one
        for (int i = 0; i < KB; i++) wr(kb(i), 1'b1);
        check("R6 debug sequence ignored", {7'd0, secure}, 8'h01);
        for (int i = 0; i < KB; i++) wr(kb(i), 1'b0);
        check("R6 no stale progress", {7'd0, secure}, 8'h00);

        // Mismatch lockout, then blank check
        do_reset(8'h80);
        for (int i = 0; i < 3; i++) wr(kb(i), 1'b0);
        wr(~kb(3), 1'b0);
        for (int i = 0; i < KB; i++) wr(kb(i), 1'b0);
        check("R7 locked after mismatch", {7'd0, secure}, 8'h01);
        pulse_blank();
        check("R8 blank opens locked part", {7'd0, secure}, 8'h00);
        check("R8 code after blank", {6'd0, code}, 8'h02);

        // Key enable off
        do_reset(8'h41);
        check("R2 redir disabled", {7'd0, redir}, 8'h01);
        check("R4 key_en low", {7'd0, key_en}, 8'h00);
        for (int i = 0; i < KB; i++) wr(kb(i), 1'b0);
        check("R4 key path closed", {7'd0, secure}, 8'h01);
        pulse_blank();
        check("R8 blank with key off", {7'd0, secure}, 8'h00);

        // Open code straight from reset
        do_reset(8'h02);
        check("R3 open code at reset", {7'd0, secure}, 8'h00);
        check("R2 redir enabled", {7'd0, redir}, 8'h00);

        repeat (2) @(posedge clk);
        summary();
        $finish;
    end

endmodule